// File: doc/BRIEF.md
# Static Memory Timing Calculator

This block turns a set of requested access timings for a static memory port into register field values that the port's timing encoding can represent. Software or a sequencer presents four durations in nanoseconds (address setup, strobe width, total cycle, and data-float time) together with a 16.16 fixed-point factor giving clock ticks per nanosecond, then pulses `start`.

The block converts each duration to ticks and moves each tick count up to the nearest legal encoded value. Any ticks added to setup or strobe are also added to the cycle. It then derives the chip-select pulse from the cycle. If that pulse had to grow, the cycle is widened to match and a further pass runs. When the values settle, it presents the packed fields with warning and fatal indications and a one-clock `done` pulse. Write and read timings share the same fields, and the chip-select setup is always zero, so neither has an output of its own.

Top module: `stm_timing_calc`

## Requirements
- R1: Each duration is converted to ticks as (ns × mul + 65536) >> 16, where mul is the 16.16 ticks-per-ns input; results wider than the internal tick width saturate.
- R2: Setup ticks are legal in 0..31 and 128..159. A value in 32..127 is raised to 128. A value above 159 becomes 159 and sets the warning.
- R3: Strobe ticks are legal in 0..63 and 256..319. A value in 64..255 is raised to 256. A value above 319 becomes 319 and sets the warning.
- R4: The amounts added to setup and strobe are added to the cycle before the cycle is snapped. Legal cycle ticks are 0..127, 256..383, 512..639 and 768..895. A gap value rises to the next range start, and a value above 895 becomes 895 with the warning.
- R5: The chip-select pulse equals the snapped cycle. A cycle above 319 sets the fatal flag.
- R6: If the chip-select pulse falls in 64..255, it and the cycle become 256 and another pass runs. A fourth pass still needing this ends with the fatal flag set.
- R7: Packing: setup_fld = {s[7], s[4:0]}, strobe_fld = {p[8], p[5:0]}, cycle_fld = {c[9:8], c[6:0]}, cs_fld = {cs[8], cs[5:0]}. Field values are meaningful only when fatal is low.
- R8: Data-float ticks above 15 are clamped to 15 and set the warning.
- R9: A `start` seen while idle latches all inputs. A `start` seen while busy is ignored, and so are input changes during the calculation. `done` is high for exactly one clock, N rising edges after the accepting edge, where N is the number of passes. Outputs hold their values until the next `done`.
- R10: During and after reset, all fields, `warn`, `fatal` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation with the present inputs |
| setup_ns | input | 16 | Requested setup time, ns |
| strobe_ns | input | 16 | Requested strobe width, ns |
| cycle_ns | input | 16 | Requested total cycle, ns |
| float_ns | input | 16 | Requested data-float time, ns |
| mul | input | 32 | Ticks per ns, 16.16 fixed point |
| setup_fld | output | 6 | Packed setup field |
| strobe_fld | output | 7 | Packed strobe field |
| cycle_fld | output | 9 | Packed cycle field |
| cs_fld | output | 7 | Packed chip-select pulse field |
| float_fld | output | 4 | Data-float ticks |
| warn | output | 1 | Some value was clamped |
| fatal | output | 1 | No legal setting was found |
| done | output | 1 | One-clock result strobe |

## Verification
Every result appears together on the edge that raises `done`. That edge is one edge after the accepting edge for a single pass, and two edges after it when the chip-select pulse forces a recalculation. For each vector the bench predicts the number of passes and counts the rising edges up to `done`, sampling on the falling edge. It then checks all fields in that same sample, and one sample later it confirms that `done` has dropped and the fields have held.

// File: rtl/stm_timing_calc.sv
module stm_timing_calc #(
  parameter int NS_W     = 16,
  parameter int MUL_W    = 32,
  parameter int FRAC     = 16,
  parameter int TW       = 12,
  parameter int MAX_PASS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NS_W-1:0]   setup_ns,
  input  logic [NS_W-1:0]   strobe_ns,
  input  logic [NS_W-1:0]   cycle_ns,
  input  logic [NS_W-1:0]   float_ns,
  input  logic [MUL_W-1:0]  mul,
  output logic [5:0]        setup_fld,
  output logic [6:0]        strobe_fld,
  output logic [8:0]        cycle_fld,
  output logic [6:0]        cs_fld,
  output logic [3:0]        float_fld,
  output logic              warn,
  output logic              fatal,
  output logic              done
);
  localparam int PW = NS_W + MUL_W + 1;
  localparam int CW = TW + 2;
  localparam int NW = $clog2(MAX_PASS + 1);

  function automatic logic [TW-1:0] ns2tick(input logic [NS_W-1:0] ns,
                                            input logic [MUL_W-1:0] m);
    logic [PW-1:0] prod;
    logic [PW-1:0] t;
    prod = PW'(ns) * PW'(m) + (PW'(1) << FRAC);
    t = prod >> FRAC;
    return (t > PW'({TW{1'b1}})) ? {TW{1'b1}} : t[TW-1:0];
  endfunction

  logic          busy;
  logic [NW-1:0] npass;
  logic [TW-1:0] s_q, p_q;
  logic [CW-1:0] c_q;
  logic [3:0]    f_q;
  logic          w_q;

  logic [TW-1:0] s_n, p_n, s_add, p_add, f_t;
  logic [CW-1:0] c_sum, c_n;
  logic          ws, wp, wc, fat_n, redo, last;

  assign f_t  = ns2tick(float_ns, mul);
  assign last = (npass == NW'(MAX_PASS - 1));

  always_comb begin
    s_n = s_q; s_add = '0; ws = 1'b0;
    if (s_q > TW'(159)) begin
      s_n = TW'(159); ws = 1'b1;
    end else if (s_q > TW'(31) && s_q < TW'(128)) begin
      s_n = TW'(128); s_add = TW'(128) - s_q;
    end

    p_n = p_q; p_add = '0; wp = 1'b0;
    if (p_q > TW'(319)) begin
      p_n = TW'(319); wp = 1'b1;
    end else if (p_q > TW'(63) && p_q < TW'(256)) begin
      p_n = TW'(256); p_add = TW'(256) - p_q;
    end

    c_sum = c_q + CW'(s_add) + CW'(p_add);
    c_n = c_sum; wc = 1'b0;
    if (c_sum > CW'(895)) begin
      c_n = CW'(895); wc = 1'b1;
    end else if (c_sum[7]) begin
      c_n = {c_sum[CW-1:8] + 1'b1, 8'h00};
    end

    fat_n = c_n > CW'(319);
    redo  = !fat_n && c_n > CW'(63) && c_n < CW'(256);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; npass <= '0;
      s_q <= '0; p_q <= '0; c_q <= '0; f_q <= '0; w_q <= 1'b0;
      setup_fld <= '0; strobe_fld <= '0; cycle_fld <= '0; cs_fld <= '0;
      float_fld <= '0; warn <= 1'b0; fatal <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        npass <= '0;
        s_q   <= ns2tick(setup_ns, mul);
        p_q   <= ns2tick(strobe_ns, mul);
        c_q   <= CW'(ns2tick(cycle_ns, mul));
        f_q   <= (f_t > TW'(15)) ? 4'd15 : f_t[3:0];
        w_q   <= f_t > TW'(15);
      end else if (busy) begin
        s_q <= s_n;
        p_q <= p_n;
        w_q <= w_q | ws | wp | wc;
        if (redo && !last) begin
          c_q   <= CW'(256);
          npass <= npass + 1'b1;
        end else begin
          busy       <= 1'b0;
          done       <= 1'b1;
          fatal      <= fat_n | redo;
          warn       <= w_q | ws | wp | wc;
          setup_fld  <= {s_n[7], s_n[4:0]};
          strobe_fld <= {p_n[8], p_n[5:0]};
          cycle_fld  <= {c_n[9:8], c_n[6:0]};
          cs_fld     <= {c_n[8], c_n[5:0]};
          float_fld  <= f_q;
        end
      end
    end
  end
endmodule

// File: rtl/stm_timing_calc_chk.sv
module stm_timing_calc_chk #(
  parameter int MAX_PASS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [5:0] setup_fld,
  input logic [6:0] strobe_fld,
  input logic [8:0] cycle_fld,
  input logic [6:0] cs_fld,
  input logic [3:0] float_fld,
  input logic       warn,
  input logic       fatal,
  input logic       done
);
  logic       pend;
  logic [7:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; age <= '0;
    end else if (start && (!pend || done)) begin
      pend <= 1'b1; age <= '0;
    end else if (done) begin
      pend <= 1'b0;
    end else if (pend) begin
      age <= age + 1'b1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pend);

  // R6
  pass_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && age >= 8'(MAX_PASS - 1)) |-> done);

  // R9
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(setup_fld) && $stable(strobe_fld) && $stable(cycle_fld) &&
               $stable(cs_fld) && $stable(float_fld) && $stable(warn) && $stable(fatal)));

  // R5
  cs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fatal) |->
      ({cycle_fld[8:7], 1'b0, cycle_fld[6:0]} == {1'b0, cs_fld[6], 2'b00, cs_fld[5:0]}));
endmodule

bind stm_timing_calc stm_timing_calc_chk #(.MAX_PASS(MAX_PASS)) u_chk (.*);

// File: tb/sim_stm_timing_calc.sv
module sim_stm_timing_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] setup_ns = '0, strobe_ns = '0, cycle_ns = '0, float_ns = '0;
  logic [31:0] mul = 32'h10000;
  logic [5:0]  setup_fld;
  logic [6:0]  strobe_fld;
  logic [8:0]  cycle_fld;
  logic [6:0]  cs_fld;
  logic [3:0]  float_fld;
  logic        warn, fatal, done;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  stm_timing_calc u0 (.*);

  typedef struct packed {
    logic [15:0] s_ns, p_ns, c_ns, f_ns;
    logic [31:0] m;
    logic [5:0]  es;
    logic [6:0]  ep;
    logic [8:0]  ec;
    logic [6:0]  ecs;
    logic [3:0]  ef;
    logic        ew, efat;
    logic [2:0]  np;
  } vec_t;

  localparam logic [31:0] U = 32'h10000;
  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{16'd2,   16'd9,   16'd29,  16'd4,  U,          6'd3,  7'd10,  9'd30,  7'd30,  4'd5,  1'b0, 1'b0, 3'd1},
    '{16'd39,  16'd19,  16'd19,  16'd0,  U,          6'd32, 7'd20,  9'd128, 7'd64,  4'd1,  1'b0, 1'b0, 3'd2},
    '{16'd0,   16'd99,  16'd9,   16'd20, U,          6'd1,  7'd64,  9'd128, 7'd64,  4'd15, 1'b1, 1'b0, 3'd1},
    '{16'd0,   16'd0,   16'd399, 16'd0,  U,          6'd0,  7'd0,   9'd0,   7'd0,   4'd0,  1'b0, 1'b1, 3'd1},
    '{16'd199, 16'd4,   16'd49,  16'd0,  U,          6'd63, 7'd5,   9'd50,  7'd50,  4'd1,  1'b1, 1'b0, 3'd1},
    '{16'd10,  16'd20,  16'd60,  16'd8,  32'h8000,   6'd6,  7'd11,  9'd31,  7'd31,  4'd5,  1'b0, 1'b0, 3'd1},
    '{16'd0,   16'd399, 16'd0,   16'd0,  U,          6'd1,  7'd127, 9'd1,   7'd1,   4'd1,  1'b1, 1'b0, 3'd1},
    '{16'd0,   16'd0,   16'd69,  16'd14, U,          6'd1,  7'd1,   9'd128, 7'd64,  4'd15, 1'b0, 1'b0, 3'd2},
    '{16'd31,  16'd0,   16'd0,   16'd0,  U,          6'd32, 7'd1,   9'd128, 7'd64,  4'd1,  1'b0, 1'b0, 3'd2},
    '{16'd0,   16'd0,   16'd318, 16'd0,  U,          6'd1,  7'd1,   9'd191, 7'd127, 4'd1,  1'b0, 1'b0, 3'd1},
    '{16'd0,   16'd0,   16'd319, 16'd0,  U,          6'd0,  7'd0,   9'd0,   7'd0,   4'd0,  1'b0, 1'b1, 3'd1},
    '{16'd0,   16'd0,   16'd999, 16'd0,  U,          6'd0,  7'd0,   9'd0,   7'd0,   4'd0,  1'b1, 1'b1, 3'd1},
    '{16'd30,  16'd62,  16'd0,   16'd0,  U,          6'd31, 7'd63,  9'd1,   7'd1,   4'd1,  1'b0, 1'b0, 3'd1},
    '{16'd0,   16'd63,  16'd0,   16'd0,  U,          6'd1,  7'd64,  9'd128, 7'd64,  4'd1,  1'b0, 1'b0, 3'd1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    setup_ns = v.s_ns; strobe_ns = v.p_ns; cycle_ns = v.c_ns;
    float_ns = v.f_ns; mul = v.m;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk); @(negedge clk); cnt++;
    end while (!done && cnt < 8);
  endtask

  task automatic check_result(input vec_t v, input int cnt, input int idx);
    logic [5:0] s0; logic [6:0] p0; logic [8:0] c0; logic [6:0] cs0; logic [3:0] f0;
    check($sformatf("R6/R9 vec%0d edges to done", idx), cnt, int'(v.np));
    check($sformatf("R5/R6 vec%0d fatal", idx), int'(fatal), int'(v.efat));
    check($sformatf("R2/R3/R4/R8 vec%0d warn", idx), int'(warn), int'(v.ew));
    if (!v.efat) begin
      check($sformatf("R1/R2/R7 vec%0d setup_fld", idx), int'(setup_fld), int'(v.es));
      check($sformatf("R1/R3/R7 vec%0d strobe_fld", idx), int'(strobe_fld), int'(v.ep));
      check($sformatf("R4/R7 vec%0d cycle_fld", idx), int'(cycle_fld), int'(v.ec));
      check($sformatf("R5/R7 vec%0d cs_fld", idx), int'(cs_fld), int'(v.ecs));
      check($sformatf("R8 vec%0d float_fld", idx), int'(float_fld), int'(v.ef));
    end
    s0 = setup_fld; p0 = strobe_fld; c0 = cycle_fld; cs0 = cs_fld; f0 = float_fld;
    @(negedge clk);
    check($sformatf("R9 vec%0d done one clock", idx), int'(done), 0);
    check($sformatf("R9 vec%0d fields hold", idx),
          int'({setup_fld, strobe_fld, cycle_fld, cs_fld, float_fld} == {s0, p0, c0, cs0, f0}), 1);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 done in reset", int'(done), 0);
    check("R10 fields in reset", int'({setup_fld, strobe_fld, cycle_fld, cs_fld, float_fld}), 0);
    check("R10 flags in reset", int'({warn, fatal}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", int'({done, warn, fatal}), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      drive(VT[0]);
      wait_done(cnt);
      check_result(VT[i], cnt, i);
      @(negedge clk);
    end

    // R9 start while busy and input changes are ignored
    drive(VT[1]);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    drive(VT[4]);
    wait_done(cnt);
    start = 1'b0;
    check_result(VT[1], cnt, 100);

    // R9 results for a fresh start after the held one
    @(negedge clk);
    drive(VT[0]);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    wait_done(cnt);
    check_result(VT[0], cnt, 101);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule